// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block is a memory-mapped real-time-clock core. A 32-bit seconds counter advances by one on each cycle where the `tick` input is high. The `tick` input is expected once per second from a prescaler outside the block. A 32-bit alarm register is compared against the value the counter is about to take. When they match and the alarm is armed in the persistent configuration register, the core latches a pending flag in its control register. The interrupt output is asserted while that flag and the control-register interrupt enable are both 1.

The seven registers (control, status, seconds, alarm, watchdog timeout, persistent0 and persistent1) each occupy a 16-byte slot. Within a slot, byte offset 0x0 is a plain write, 0x4 ORs the written bits into the register and 0x8 clears the written bits. Software can therefore change one bit without a read-modify-write. The millisecond interrupt enable, the watchdog enable and the watchdog timeout are storage only. Reads are combinational. A reset clears configuration but leaves the seconds count alone.

Top module: `rtc_alarm_core`

## Requirements
- R1: When `rstN` is low, control, alarm, watchdog, persistent0 and persistent1 are cleared and `irqAlarm` goes low. The seconds counter keeps its value across reset.
- R2: A cycle with `tick` high and no seconds write raises the seconds register by exactly 1. Without a tick the register holds its value.
- R3: The seconds counter counts through 0xFFFFFFFF and wraps to 0x00000000.
- R4: On a tick where the incremented count equals the alarm register and persistent0 bit2 (alarm arm) is 1, control bit2 (pending) becomes 1. If persistent0 bit1 (wake enable) is also 1, persistent0 bit7 (wake flag) becomes 1 as well.
- R5: With persistent0 bit2 at 0, a matching tick leaves control bit2 at 0.
- R6: `irqAlarm` is high exactly when control bit2 and control bit0 (alarm interrupt enable) are both 1.
- R7: Register slots sit at 0x00 control, 0x10 status, 0x30 seconds, 0x40 alarm, 0x50 watchdog timeout, 0x60 persistent0 and 0x70 persistent1. Slot offset 0x0 writes, 0x4 ORs and 0x8 clears. Writes at offset 0xC are ignored. A read at any offset of a slot returns that register.
- R8: Writing 0x4 to control offset 0x8 acknowledges the alarm. If an alarm match occurs in the same cycle, the pending flag stays set.
- R9: Status reads 0x80000000 (bit31 shows the clock is present). Writes to it have no effect.
- R10: Control keeps only bits 0, 1, 2 and 4, and persistent0 keeps only bits 1, 2 and 7; all other bits read 0. Control bit1 (millisecond interrupt enable) and bit4 (watchdog enable) do not affect `irqAlarm`.
- R11: A software write to seconds takes priority over a tick in the same cycle. A write that makes seconds equal to the alarm does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second advance strobe |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address: slot in bits 6:4, alias in bits 3:2 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach from the ports is an alarm match that lands in the same cycle as a clear-alias acknowledge. To reach it, the bench first raises the flag with one match and then moves the alarm one second ahead. It then drives `tick` and the clear write on the same clock edge, and the flag must survive. Two other collisions are reached the same way: a wrap from the all-ones count, and a seconds write that coincides with a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SLOTS   = 8;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_STAT = 1;
  localparam int SLOT_SEC  = 3;
  localparam int SLOT_ALM  = 4;
  localparam int SLOT_WDOG = 5;
  localparam int SLOT_P0   = 6;
  localparam int SLOT_P1   = 7;

  // control bit positions
  localparam int CB_ALM_IE   = 0;
  localparam int CB_MS_IE    = 1;
  localparam int CB_ALM_PEND = 2;
  localparam int CB_WDOG_EN  = 4;
  // persistent0 bit positions
  localparam int PB_WAKE_EN  = 1;
  localparam int PB_ALM_ARM  = 2;
  localparam int PB_WAKE_FLG = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic [SLOTS-1:0]  wrSel;
    wrOp_e             op;
    logic [SLOT_W-1:0] rdSlot;
    logic              rdHit;
  } busStrobe_t;
endpackage

// File: rtl/rtc_busdec.sv
module rtc_busdec
  import rtc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output busStrobe_t    stb
);
  localparam int SLOT_LSB = 4;
  localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;

  logic inRange;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    inRange = (addr[AW-1:SLOT_MSB+1] == '0);
    slot    = addr[SLOT_MSB:SLOT_LSB];
    stb.rdSlot = slot;
    stb.rdHit  = inRange;
    stb.op     = wrOp_e'(addr[3:2]);
    stb.wrSel  = '0;
    if (wrEn && inRange && addr[1:0] == 2'b00 && addr[3:2] != 2'b11)
      stb.wrSel[slot] = 1'b1;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  busStrobe_t    stb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irqAlarm
);
  localparam logic [DW-1:0] ONE       = DW'(1);
  localparam logic [DW-1:0] CTRL_MASK = (ONE << CB_ALM_IE) | (ONE << CB_MS_IE) |
                                        (ONE << CB_ALM_PEND) | (ONE << CB_WDOG_EN);
  localparam logic [DW-1:0] P0_MASK   = (ONE << PB_WAKE_EN) | (ONE << PB_ALM_ARM) |
                                        (ONE << PB_WAKE_FLG);
  localparam logic [DW-1:0] STAT_VAL  = ONE << (DW-1);

  logic [DW-1:0] ctrlReg, secReg, almReg, wdogReg, p0Reg, p1Reg;
  logic [DW-1:0] ctrlNext, secNext, almNext, wdogNext, p0Next, p1Next;
  logic [DW-1:0] secInc;
  logic          secWr, alarmHit;
  logic          unusedSel;

  assign unusedSel = ^{stb.wrSel[SLOT_STAT], stb.wrSel[2]};

  function automatic logic [DW-1:0] applyOp(logic [DW-1:0] old,
                                            logic [DW-1:0] d, wrOp_e op);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return old | d;
      OP_CLR:   return old & ~d;
      default:  return old;
    endcase
  endfunction

  always_comb begin
    secWr    = stb.wrSel[SLOT_SEC];
    secInc   = secReg + ONE;
    alarmHit = tick && !secWr && (secInc == almReg) && p0Reg[PB_ALM_ARM];

    secNext = secReg;
    if (secWr)     secNext = applyOp(secReg, wrData, stb.op);
    else if (tick) secNext = secInc;

    ctrlNext = ctrlReg;
    if (stb.wrSel[SLOT_CTRL]) ctrlNext = applyOp(ctrlReg, wrData, stb.op) & CTRL_MASK;
    if (alarmHit) ctrlNext[CB_ALM_PEND] = 1'b1;

    p0Next = p0Reg;
    if (stb.wrSel[SLOT_P0]) p0Next = applyOp(p0Reg, wrData, stb.op) & P0_MASK;
    if (alarmHit && p0Reg[PB_WAKE_EN]) p0Next[PB_WAKE_FLG] = 1'b1;

    almNext  = stb.wrSel[SLOT_ALM]  ? applyOp(almReg,  wrData, stb.op) : almReg;
    wdogNext = stb.wrSel[SLOT_WDOG] ? applyOp(wdogReg, wrData, stb.op) : wdogReg;
    p1Next   = stb.wrSel[SLOT_P1]   ? applyOp(p1Reg,   wrData, stb.op) : p1Reg;
  end

  // seconds count survives reset
  always_ff @(posedge clk) secReg <= secNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      almReg  <= '0;
      wdogReg <= '0;
      p0Reg   <= '0;
      p1Reg   <= '0;
    end else begin
      ctrlReg <= ctrlNext;
      almReg  <= almNext;
      wdogReg <= wdogNext;
      p0Reg   <= p0Next;
      p1Reg   <= p1Next;
    end
  end

  assign irqAlarm = ctrlReg[CB_ALM_PEND] & ctrlReg[CB_ALM_IE];

  always_comb begin
    rdData = '0;
    if (stb.rdHit) begin
      case (int'(stb.rdSlot))
        SLOT_CTRL: rdData = ctrlReg;
        SLOT_STAT: rdData = STAT_VAL;
        SLOT_SEC:  rdData = secReg;
        SLOT_ALM:  rdData = almReg;
        SLOT_WDOG: rdData = wdogReg;
        SLOT_P0:   rdData = p0Reg;
        SLOT_P1:   rdData = p1Reg;
        default:   rdData = '0;
      endcase
    end
  end

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !secWr) |=> (secReg == $past(secReg) + ONE));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !secWr) |=> $stable(secReg));

  // R4
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !secWr && p0Reg[PB_ALM_ARM] && (secReg + ONE == almReg)) |=> ctrlReg[CB_ALM_PEND]);

  // R4
  wake_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !secWr && p0Reg[PB_ALM_ARM] && p0Reg[PB_WAKE_EN] && (secReg + ONE == almReg))
      |=> p0Reg[PB_WAKE_FLG]);

  // R5
  no_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!p0Reg[PB_ALM_ARM] && !ctrlReg[CB_ALM_PEND] && !stb.wrSel[SLOT_CTRL])
      |=> !ctrlReg[CB_ALM_PEND]);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlReg[CB_ALM_PEND]) |-> !irqAlarm);

  // R9
  status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdHit && int'(stb.rdSlot) == SLOT_STAT) |-> (rdData == STAT_VAL));
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irqAlarm
);
  busStrobe_t stb;

  rtc_busdec #(.AW(AW)) uDec (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  rtc_datapath #(.DW(DW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .stb      (stb),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqAlarm (irqAlarm)
  );
endmodule

// File: tb/sim_rtc_alarm_core.sv
module sim_rtc_alarm_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqAlarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_core u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqAlarm(irqAlarm)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [NVEC] = '{
    {8'h30, 32'h12345678, 8'h30, 32'h12345678},  // R7 plain write
    {8'h34, 32'h000000F0, 8'h30, 32'h123456F8},  // R7 set alias
    {8'h38, 32'h12340000, 8'h30, 32'h000056F8},  // R7 clear alias
    {8'h40, 32'hAAAA5555, 8'h44, 32'hAAAA5555},  // R7 read via alias
    {8'h50, 32'hDEADBEEF, 8'h50, 32'hDEADBEEF},
    {8'h58, 32'hFF00FF00, 8'h50, 32'h00AD00EF},
    {8'h70, 32'h80000000, 8'h70, 32'h80000000},
    {8'h74, 32'h00000001, 8'h70, 32'h80000001},
    {8'h00, 32'hFFFFFFFF, 8'h00, 32'h00000017},  // R10 control mask
    {8'h08, 32'h00000005, 8'h00, 32'h00000012},
    {8'h04, 32'h00000001, 8'h00, 32'h00000013},
    {8'h0C, 32'h00000000, 8'h00, 32'h00000013},  // R7 reserved alias
    {8'h10, 32'h00000000, 8'h10, 32'h80000000},  // R9 status
    {8'h60, 32'hFFFFFFFF, 8'h60, 32'h00000086},  // R10 p0 mask
    {8'h68, 32'h00000082, 8'h60, 32'h00000004},
    {8'h00, 32'h00000000, 8'h00, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrTick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic irqChk(input string req, input logic exp);
    #1;
    check(req, {31'd0, irqAlarm}, {31'd0, exp});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rdChk("R1 ctrl after reset", 8'h00, 32'h0);
    irqChk("R1 irq after reset", 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rdChk("R7 vector", VEC[i][39:32], VEC[i][31:0]);
    end

    // R1: seconds survive reset, config cleared
    wr(8'h30, 32'h00000055);
    wr(8'h00, 32'h00000013);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rdChk("R1 seconds kept", 8'h30, 32'h00000055);
    rdChk("R1 ctrl cleared", 8'h00, 32'h0);
    rdChk("R1 alarm cleared", 8'h40, 32'h0);
    rdChk("R1 p1 cleared", 8'h70, 32'h0);
    irqChk("R1 irq low", 1'b0);

    // R2
    wr(8'h30, 32'd100);
    doTick();
    rdChk("R2 increment", 8'h30, 32'd101);
    repeat (3) @(negedge clk);
    rdChk("R2 hold", 8'h30, 32'd101);

    // R3
    wr(8'h30, 32'hFFFFFFFF);
    doTick();
    rdChk("R3 wrap", 8'h30, 32'h0);

    // R4 / R6 / R8
    wr(8'h30, 32'd9);
    wr(8'h40, 32'd10);
    wr(8'h64, 32'h00000006);
    doTick();
    rdChk("R4 pending set", 8'h00, 32'h00000004);
    rdChk("R4 wake flag", 8'h60, 32'h00000086);
    irqChk("R6 irq masked", 1'b0);
    wr(8'h04, 32'h00000001);
    irqChk("R6 irq raised", 1'b1);
    wr(8'h08, 32'h00000004);
    rdChk("R8 ack", 8'h00, 32'h00000001);
    irqChk("R8 irq dropped", 1'b0);
    wr(8'h68, 32'h00000080);
    rdChk("R7 wake flag cleared", 8'h60, 32'h00000006);

    // R5
    wr(8'h68, 32'h00000004);
    wr(8'h30, 32'd19);
    wr(8'h40, 32'd20);
    doTick();
    rdChk("R5 no pending", 8'h00, 32'h00000001);
    irqChk("R5 irq low", 1'b0);

    // R8 race: match and acknowledge in one cycle
    wr(8'h64, 32'h00000004);
    wr(8'h30, 32'd29);
    wr(8'h40, 32'd30);
    doTick();
    wr(8'h40, 32'd31);
    wrTick(8'h08, 32'h00000004);
    rdChk("R8 match beats ack", 8'h00, 32'h00000005);
    irqChk("R8 irq kept", 1'b1);

    // R11
    wr(8'h08, 32'h00000004);
    wrTick(8'h30, 32'd200);
    rdChk("R11 write beats tick", 8'h30, 32'd200);
    wr(8'h40, 32'd300);
    wr(8'h30, 32'd300);
    rdChk("R11 write no alarm", 8'h00, 32'h00000001);

    // R10
    wr(8'h04, 32'h00000012);
    rdChk("R10 ctrl bits", 8'h00, 32'h00000013);
    irqChk("R10 no irq from ms/wdog", 1'b0);

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule